// File: doc/BRIEF.md
# Differential Sensor Offset Self-Calibration Controller

This block is the digital core of a two-mode differential magnetic speed sensor. It receives signed samples of the differential signal from an ADC. It tracks the highest and lowest sample seen since the last output edge and drives a single sign output. It also refines a signed code for an offset-cancellation DAC. The analog front end, the DAC itself and the output driver sit outside the block.

After reset the block is in startup mode. Here the output switches when the uncompensated signal has moved more than a minimum swing away from its last peak. Each fall edge confirms a maximum and each rise edge confirms a minimum. When both have been confirmed, their mean is folded into the DAC code. After a set number of these refinements the block enters running mode. From then on the output follows an external comparator that sees the offset-corrected signal, and the DAC code is frozen.

A watchdog counts clock cycles since the last output edge. When the count reaches a long period, the peak trackers restart without moving the output, the mode or the DAC code.

Top module: `diffsense_cal_ctrl`

## Requirements
- R1: While reset is held and right after it, `sense_out` is 1, `run_mode` is 0 and `dac_code` is 0.
- R2: In startup mode, on a valid sample, the output falls if it is 1 and the sample lies more than MIN_SWING below the highest sample tracked since the last restart. It rises if it is 0 and the sample lies more than MIN_SWING above the lowest tracked sample. The tracked range includes the current sample. The new output appears on the clock after that sample.
- R3: A valid sample whose tracked range (maximum minus minimum, including that sample) is MIN_SWING or less never changes the output, in either mode.
- R4: Once a fall edge and a rise edge have both occurred since the last update in startup mode, `dac_code` becomes the saturating sum of `dac_code` and (max + min) arithmetically shifted right by 1 + (12 - 10). Here max is the tracked maximum at the fall edge and min is the tracked minimum at the rise edge. `dac_code` is 10-bit two's complement, clamped to -512..511. The update is visible two clocks after the completing sample.
- R5: `run_mode` goes to 1 on the same clock as the CAL_ITERS-th DAC update (default 3) and never returns to 0 before reset.
- R6: In running mode, on a valid sample, the output takes the value of `cmp_in` when the two differ and the tracked range exceeds MIN_SWING.
- R7: In running mode `dac_code` does not change.
- R8: After RECAL_CYCLES clocks without an output edge, the peak trackers restart. `sense_out`, `run_mode` and `dac_code` keep their values.
- R9: Every output edge restarts the recalibration count and the peak trackers. The next sample starts a fresh range.
- R10: Cycles with `smp_vld` low affect neither the output nor the tracked range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all timers count it |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, one valid sample per high cycle |
| smp_data | input | 12 | Signed differential sample |
| cmp_in | input | 1 | Comparator result on the corrected signal, used in running mode |
| dac_code | output | 10 | Signed offset-cancellation code |
| run_mode | output | 1 | 0 in startup mode, 1 in running mode |
| sense_out | output | 1 | Field sign output, 1 after reset |

## Verification
The assertions assume that reset is low from time zero for at least one clock. They also assume that `cmp_in` and `smp_data` matter only in cycles where `smp_vld` is high. RECAL_CYCLES must be at least 2, and the sample width must not be smaller than the DAC width. The bench drives every input on the falling clock edge. It changes `smp_data` and `cmp_in` freely while `smp_vld` is low to show that they are ignored. It shortens the recalibration period so that both a watchdog restart and an edge-driven reload happen within the run.

// File: rtl/diffcal_pkg.sv
// Shared types for the differential-sensor calibration controller.
// Assumes nothing beyond a two-state operating mode.
package diffcal_pkg;

    typedef enum logic {
        CAL_STARTUP = 1'b0,
        CAL_RUNNING = 1'b1
    } cal_mode_e;

endpackage

// File: rtl/dsc_peak_track.sv
// Tracks the running maximum and minimum of the sample stream since the
// last restart. nmax/nmin combine the stored range with the present
// sample, so callers see the range including the sample on the bus.
// Assumes restart has priority over a coincident valid sample.
module dsc_peak_track #(
    parameter int SMP_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld,
    input  logic                    restart,
    input  logic signed [SMP_W-1:0] smp,
    output logic signed [SMP_W-1:0] nmax,
    output logic signed [SMP_W-1:0] nmin
);

    logic                    have_q;
    logic signed [SMP_W-1:0] max_q;
    logic signed [SMP_W-1:0] min_q;

    // Range including the present sample; an empty tracker takes the sample alone.
    always_comb begin
        if (!have_q) begin
            nmax = smp;
            nmin = smp;
        end else begin
            nmax = (smp > max_q) ? smp : max_q;
            nmin = (smp < min_q) ? smp : min_q;
        end
    end

    // Store the range on each valid sample, empty it on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            max_q  <= '0;
            min_q  <= '0;
        end else if (restart) begin
            have_q <= 1'b0;
        end else if (vld) begin
            have_q <= 1'b1;
            max_q  <= nmax;
            min_q  <= nmin;
        end
    end

    // R10: a cycle without a sample leaves the stored range untouched
    a_r10_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld && !restart) |=> ($stable(max_q) && $stable(min_q) && $stable(have_q)));

    // R9: a restart always leaves the tracker empty
    a_r9_restart_empties: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !have_q);

endmodule

// File: rtl/dsc_sw_decide.sv
// Decides the output level. In startup it detects transitions of the raw
// signal against the tracked peaks. In running mode it follows the
// comparator. Both paths require the tracked range to exceed MIN_SWING.
// Assumes nmax >= smp >= nmin, as supplied by the peak tracker.
module dsc_sw_decide #(
    parameter int SMP_W     = 12,
    parameter int MIN_SWING = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld,
    input  logic                    running,
    input  logic                    cmp_in,
    input  logic signed [SMP_W-1:0] smp,
    input  logic signed [SMP_W-1:0] nmax,
    input  logic signed [SMP_W-1:0] nmin,
    output logic                    out,
    output logic                    rise,
    output logic                    fall
);

    localparam int DW = SMP_W + 1;
    localparam logic signed [DW-1:0] THR = DW'(MIN_SWING);

    logic signed [DW-1:0] up_d;
    logic signed [DW-1:0] dn_d;
    logic signed [DW-1:0] swing_d;
    logic                 wide;

    // Distances of the sample from the tracked peaks and the full range.
    always_comb begin
        up_d    = DW'(smp)  - DW'(nmin);
        dn_d    = DW'(nmax) - DW'(smp);
        swing_d = DW'(nmax) - DW'(nmin);
        wide    = swing_d > THR;
    end

    // Edge decision per mode; only valid samples may switch.
    always_comb begin
        if (running) begin
            rise = vld && !out && cmp_in && wide;
            fall = vld && out && !cmp_in && wide;
        end else begin
            rise = vld && !out && (up_d > THR);
            fall = vld && out && (dn_d > THR);
        end
    end

    // Output register, high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out <= 1'b1;
        else if (rise)
            out <= 1'b1;
        else if (fall)
            out <= 1'b0;
    end

    // R10: no sample, no output change
    a_r10_no_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(out));

    // R3: a narrow range never toggles the output
    a_r3_small_swing_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && (swing_d <= THR)) |=> $stable(out));

    // R6: in running mode a change always lands on the comparator level
    a_r6_follows_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && running) |=> ((out == $past(out)) || (out == $past(cmp_in))));

endmodule

// File: rtl/dsc_dac_accum.sv
// Latches the confirmed maximum at each fall edge and the confirmed
// minimum at each rise edge. Once both are present it adds their
// scaled mean to the DAC code with saturation, and counts refinements up
// to CAL_ITERS before entering running mode.
// Assumes SMP_W >= DAC_W and CAL_ITERS >= 1.
module dsc_dac_accum
    import diffcal_pkg::*;
#(
    parameter int SMP_W     = 12,
    parameter int DAC_W     = 10,
    parameter int CAL_ITERS = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rise,
    input  logic                    fall,
    input  logic                    recal,
    input  logic signed [SMP_W-1:0] nmax,
    input  logic signed [SMP_W-1:0] nmin,
    output logic signed [DAC_W-1:0] dac_code,
    output logic                    running
);

    localparam int SHIFT  = SMP_W - DAC_W;
    localparam int ACC_W  = SMP_W + 2;
    localparam int ITER_W = $clog2(CAL_ITERS + 1);
    localparam logic signed [ACC_W-1:0] ACC_HI = ACC_W'(2 ** (DAC_W - 1) - 1);
    localparam logic signed [ACC_W-1:0] ACC_LO = -ACC_HI - ACC_W'(1);

    cal_mode_e               mode_q;
    logic signed [SMP_W-1:0] lat_max_q;
    logic signed [SMP_W-1:0] lat_min_q;
    logic                    got_max_q;
    logic                    got_min_q;
    logic [ITER_W-1:0]       iter_q;
    logic                    upd;
    logic signed [ACC_W-1:0] sum_x;
    logic signed [ACC_W-1:0] acc;
    logic signed [DAC_W-1:0] dac_next;

    assign running = (mode_q == CAL_RUNNING);
    assign upd     = got_max_q && got_min_q && !running;

    // Scaled mean of the peak pair added to the code, clamped to the DAC range.
    always_comb begin
        sum_x = ACC_W'(lat_max_q) + ACC_W'(lat_min_q);
        acc   = ACC_W'(dac_code) + (sum_x >>> (SHIFT + 1));
        if (acc > ACC_HI)
            dac_next = DAC_W'(ACC_HI);
        else if (acc < ACC_LO)
            dac_next = DAC_W'(ACC_LO);
        else
            dac_next = DAC_W'(acc);
    end

    // Peak confirmation flags and latches; update clears, new edges set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_max_q <= 1'b0;
            got_min_q <= 1'b0;
            lat_max_q <= '0;
            lat_min_q <= '0;
        end else if (recal) begin
            got_max_q <= 1'b0;
            got_min_q <= 1'b0;
        end else begin
            got_max_q <= (got_max_q && !upd) || (fall && !running);
            got_min_q <= (got_min_q && !upd) || (rise && !running);
            if (fall && !running) lat_max_q <= nmax;
            if (rise && !running) lat_min_q <= nmin;
        end
    end

    // DAC code refinement, iteration count and mode change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code <= '0;
            iter_q   <= '0;
            mode_q   <= CAL_STARTUP;
        end else if (upd && !recal) begin
            dac_code <= dac_next;
            iter_q   <= iter_q + ITER_W'(1);
            if (iter_q == ITER_W'(CAL_ITERS - 1))
                mode_q <= CAL_RUNNING;
        end
    end

    // R7: running mode freezes the code
    a_r7_dac_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(dac_code));

    // R5: running mode is sticky
    a_r5_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    // R4: the code moves only once a full peak pair has been confirmed
    a_r4_needs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !(got_max_q && got_min_q) |=> $stable(dac_code));

    // R5: the iteration count never passes its limit
    a_r5_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        iter_q <= ITER_W'(CAL_ITERS));

endmodule

// File: rtl/dsc_recal_timer.sv
// Counts clocks since the last output edge and emits a one-cycle
// recalibration pulse after PERIOD clocks without an edge.
// Assumes PERIOD >= 2.
module dsc_recal_timer #(
    parameter int PERIOD = 1045200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_edge,
    output logic recal
);

    localparam int CNT_W = $clog2(PERIOD);

    logic [CNT_W-1:0] cnt_q;
    logic             term;

    assign term  = (cnt_q == CNT_W'(PERIOD - 1));
    assign recal = term && !sw_edge;

    // Reload on an edge or at the end of a period, otherwise count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (sw_edge || term)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // R8: the count stays inside one period
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(PERIOD));

    // R9: an output edge always restarts the count
    a_r9_edge_reload: assert property (@(posedge clk) disable iff (!rst_n)
        sw_edge |=> (cnt_q == '0));

endmodule

// File: rtl/diffsense_cal_ctrl.sv
// Top level of the differential-sensor calibration controller. It joins the
// peak tracker, the output decision, the DAC code accumulator and the
// recalibration watchdog. Default RECAL_CYCLES is 780 ms of a 1.34 MHz clock.
// Assumes smp_data and cmp_in are meaningful only while smp_vld is high.
module diffsense_cal_ctrl #(
    parameter int SMP_W       = 12,
    parameter int DAC_W       = 10,
    parameter int CAL_ITERS   = 3,
    parameter int MIN_SWING   = 64,
    parameter int RECAL_CYCLES = 1045200
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic                    cmp_in,
    output logic signed [DAC_W-1:0] dac_code,
    output logic                    run_mode,
    output logic                    sense_out
);

    logic signed [SMP_W-1:0] nmax;
    logic signed [SMP_W-1:0] nmin;
    logic                    rise;
    logic                    fall;
    logic                    recal;
    logic                    sw_edge;

    assign sw_edge = rise || fall;

    dsc_peak_track #(.SMP_W(SMP_W)) u_peak (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (smp_vld),
        .restart (sw_edge || recal),
        .smp     (smp_data),
        .nmax    (nmax),
        .nmin    (nmin)
    );

    dsc_sw_decide #(.SMP_W(SMP_W), .MIN_SWING(MIN_SWING)) u_decide (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (smp_vld),
        .running (run_mode),
        .cmp_in  (cmp_in),
        .smp     (smp_data),
        .nmax    (nmax),
        .nmin    (nmin),
        .out     (sense_out),
        .rise    (rise),
        .fall    (fall)
    );

    dsc_dac_accum #(.SMP_W(SMP_W), .DAC_W(DAC_W), .CAL_ITERS(CAL_ITERS)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .recal    (recal),
        .nmax     (nmax),
        .nmin     (nmin),
        .dac_code (dac_code),
        .running  (run_mode)
    );

    dsc_recal_timer #(.PERIOD(RECAL_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_edge (sw_edge),
        .recal   (recal)
    );

    // R8: a recalibration keeps output, mode and code where they were
    a_r8_recal_locks: assert property (@(posedge clk) disable iff (!rst_n)
        recal |=> ($stable(sense_out) && $stable(run_mode) && $stable(dac_code)));

    // R1: the first cycle after reset shows the reset state
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (sense_out && !run_mode && (dac_code == '0)));

endmodule

// File: tb/diffsense_cal_ctrl_test.sv
module diffsense_cal_ctrl_test;

    localparam int NV = 28;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_vld = 1'b0;
    logic signed [11:0] smp_data = '0;
    logic               cmp_in = 1'b0;
    logic signed [9:0]  dac_code;
    logic               run_mode;
    logic               sense_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    diffsense_cal_ctrl #(.RECAL_CYCLES(300)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (smp_vld),
        .smp_data  (smp_data),
        .cmp_in    (cmp_in),
        .dac_code  (dac_code),
        .run_mode  (run_mode),
        .sense_out (sense_out)
    );

    // Vectors: startup calibration (R2, R3, R4, R5), then running mode (R6, R3, R7).
    localparam int V_SMP [NV] = '{100, 300, 250, 200, 0, -140, -100, -60,
                                  100, 260, 180, 0, -300, -200,
                                  -10, 90, 20, -50, -90, -20,
                                  0, 50, 100, 100, -10, -10, 200, 200};
    localparam int V_CMP [NV] = '{0, 0, 0, 0, 0, 0, 0, 0,
                                  0, 0, 0, 0, 0, 0,
                                  0, 0, 0, 0, 0, 0,
                                  0, 0, 0, 1, 1, 1, 1, 0};
    localparam int V_OUT [NV] = '{1, 1, 1, 0, 0, 0, 0, 1,
                                  1, 1, 0, 0, 0, 1,
                                  1, 1, 0, 0, 0, 1,
                                  1, 1, 0, 0, 1, 1, 1, 0};
    localparam int V_DAC [NV] = '{0, 0, 0, 0, 0, 0, 0, 20,
                                  20, 20, 20, 20, 20, 15,
                                  15, 15, 15, 15, 15, 15,
                                  15, 15, 15, 15, 15, 15, 15, 15};
    localparam int V_MOD [NV] = '{0, 0, 0, 0, 0, 0, 0, 0,
                                  0, 0, 0, 0, 0, 0,
                                  0, 0, 0, 0, 0, 1,
                                  1, 1, 1, 1, 1, 1, 1, 1};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int smp, input bit c);
        @(negedge clk);
        smp_vld  = 1'b1;
        smp_data = 12'(smp);
        cmp_in   = c;
        @(negedge clk);
        smp_vld  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic sat_pair();
        send(2000, 0);
        send(2047, 0);
        send(1900, 0);
        send(1800, 0);
        send(1900, 0);
        idle(1);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        idle(3);
        chk("R1 out in reset", int'(sense_out), 1);
        chk("R1 mode in reset", int'(run_mode), 0);
        chk("R1 dac in reset", int'(dac_code), 0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 out after reset", int'(sense_out), 1);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            send(V_SMP[i], V_CMP[i][0]);
            idle(1);
            chk($sformatf("R2/R3/R6 out vec%0d", i), int'(sense_out), V_OUT[i]);
            chk($sformatf("R4/R7 dac vec%0d", i), int'(dac_code), V_DAC[i]);
            chk($sformatf("R5 mode vec%0d", i), int'(run_mode), V_MOD[i]);
        end

        // R10: data without strobe is ignored (out is 0, trackers empty)
        @(negedge clk);
        smp_data = -12'sd2000;
        cmp_in   = 1'b1;
        idle(5);
        chk("R10 out with strobe low", int'(sense_out), 0);
        send(0, 1);
        idle(1);
        chk("R10 range not widened by ignored data", int'(sense_out), 0);
        chk("R7 dac frozen in running", int'(dac_code), 15);

        // R8: recalibration forgets the old peak but holds the output
        do_reset();
        send(100, 0);
        send(300, 0);
        idle(310);
        chk("R8 out held across recal", int'(sense_out), 1);
        chk("R8 mode held across recal", int'(run_mode), 0);
        send(200, 0);
        idle(1);
        chk("R8 old max forgotten", int'(sense_out), 1);
        idle(250);
        send(130, 0);
        idle(1);
        chk("R2 fall on fresh range", int'(sense_out), 0);

        // R9: the edge reloaded the timer, so the range survives past the old deadline
        send(-100, 0);
        idle(100);
        send(-20, 0);
        idle(1);
        chk("R9 range kept after edge reload", int'(sense_out), 1);

        // R4: saturation of the DAC code
        do_reset();
        sat_pair();
        chk("R4 first large step", int'(dac_code), 480);
        sat_pair();
        chk("R4 positive clamp", int'(dac_code), 511);
        chk("R5 mode after two updates", int'(run_mode), 0);
        sat_pair();
        chk("R4 clamp held", int'(dac_code), 511);
        chk("R5 mode after third update", int'(run_mode), 1);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule